// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side serial engine of a byte-addressed 8K x 8 nonvolatile memory. It runs entirely on the serial clock. Bits are taken from the serial input on rising clock edges, and the serial output changes after falling edges, so both clock-idle-low and clock-idle-high hosts are served. The first byte after select is an opcode. For array commands a 16-bit address follows, and only its low 13 bits are kept. After that the block either streams array bytes with an address that increments and wraps, shifts out the status byte, or hands each incoming data byte to a write sequencer with a one-cycle strobe.

Array bytes come from a synchronous memory port clocked by the rising serial clock. Each byte is fetched on the rising edge that completes the previous byte, so the byte is ready for the falling edge that starts it. The select line acts as an asynchronous reset for the whole serial state. A pause input freezes the sequence at the exact bit where it stands. Pause changes are honoured only while the serial clock is low.

Top module: `spimem_front`

## Requirements
- R1: After the 8th rising edge of a selection, `cmd_o` shows the decoded opcode (MSB first): 0x06 gives 1, 0x04 gives 2, 0x05 gives 3, 0x01 gives 4, 0x03 gives 5, 0x02 gives 6. Before that, and for any other opcode, it shows 0.
- R2: An unknown opcode makes the block ignore every further bit until deselect: `cmd_o` stays 0, the output is never driven, and no strobe and no memory fetch occur.
- R3: For codes 5 and 6, the 16 bits after the opcode form an address, MSB first. `addr_o` holds its low 13 bits from the 24th rising edge on.
- R4: For code 5, the byte at the address appears MSB first on `ser_out`, starting at the falling edge after the 24th rising edge. Each following byte comes from the next address, and 0x1FFF is followed by 0x0000 for as long as clocks arrive.
- R5: For code 3, `stat_i` is captured and shifted out MSB first from the falling edge after the 8th rising edge. It is captured again at every later byte boundary.
- R6: For codes 4 and 6, every 8th bit after the header (opcode, plus the address for code 6) puts the byte on `wdata_o` and raises `wstb_o` until the next rising edge that is not paused.
- R7: `pause_n` low, applied while the clock is low, makes the block ignore clock edges and the data input, and keeps `ser_oe` low. Raising it again while the clock is low resumes the transfer from the bit where it stopped.
- R8: While `sel_n` is high, `ser_oe`, `wstb_o` and `mem_rd_o` are 0 and `cmd_o` is 0. A command that is cut short leaves nothing behind for the next selection.
- R9: After `rst_n` is released, no command is accepted until `sel_n` has been high at least once.
- R10: A host that idles the clock high (first edge falling) gets the same results as one that idles it low.
- R11: `mem_rd_o` pulses for one rising edge per array byte, with the byte address on `mem_addr_o`. A read of N bytes makes N+1 fetches, because the last fetch prepares a byte that is never shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-up reset, active low |
| sel_n | input | 1 | Device select, active low; high clears the serial state |
| ser_clk | input | 1 | Serial clock |
| ser_in | input | 1 | Serial data in |
| pause_n | input | 1 | Pause request, active low |
| stat_i | input | 8 | Status byte from the protection unit |
| mem_rdata_i | input | 8 | Array read data, valid after the fetch edge |
| ser_out | output | 1 | Serial data out |
| ser_oe | output | 1 | Output driver enable for `ser_out` |
| cmd_o | output | 3 | Decoded command code |
| addr_o | output | 13 | Captured start address |
| wdata_o | output | 8 | Last received data byte |
| wstb_o | output | 1 | Data byte strobe |
| mem_rd_o | output | 1 | Array fetch request |
| mem_addr_o | output | 13 | Array fetch address |

## Verification
The decoded command is due right after the 8th rising edge, and the address right after the 24th. Read data and status bits are due one falling edge after their byte boundary, and the write strobe is due at the rising edge that completes each data byte. The bench model moves the clock in half periods and samples every output in the low half, just before the next rising edge. By then every register on the path has settled and no edge is pending. Pause checks are made with the clock held low between the freeze and the release. Fetch and strobe counts are taken from monitors on the clock edge at which each is defined.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_WEN_SET = 3'd1,
    CMD_WEN_CLR = 3'd2,
    CMD_STAT_RD = 3'd3,
    CMD_STAT_WR = 3'd4,
    CMD_ARR_RD  = 3'd5,
    CMD_ARR_WR  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_ARD,
    PH_STAT,
    PH_DIN,
    PH_SKIP
  } phase_e;

  localparam logic [BYTE_W-1:0] OP_WEN_SET = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEN_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_ARR_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_ARR_WR  = 8'h02;

  function automatic cmd_e op_decode(input logic [BYTE_W-1:0] op);
    cmd_e c;
    case (op)
      OP_WEN_SET: c = CMD_WEN_SET;
      OP_WEN_CLR: c = CMD_WEN_CLR;
      OP_STAT_RD: c = CMD_STAT_RD;
      OP_STAT_WR: c = CMD_STAT_WR;
      OP_ARR_RD:  c = CMD_ARR_RD;
      OP_ARR_WR:  c = CMD_ARR_WR;
      default:    c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spimem_sess.sv
// Session qualifier: arms after the first deselect following power-up,
// and freezes the serial engine while a pause is pending.
module spimem_sess (
  input  logic rst_n,
  input  logic sel_n,
  input  logic ser_clk,
  input  logic pause_n,
  output logic sess_on_o,
  output logic held_o
);

  logic armed_q;
  logic held_q;

  // Select must go high once after power-up before a command is taken.
  always_ff @(posedge sel_n or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  assign sess_on_o = rst_n & armed_q & ~sel_n;

  // Pause is transparent only while the serial clock is low, so a change
  // made while the clock is high waits for the next low phase.
  always_latch begin
    if (!ser_clk) begin
      held_q <= ~pause_n;
    end
  end

  assign held_o = held_q & sess_on_o;

endmodule

// File: rtl/spimem_rx.sv
// Rising-edge half: opcode, address, write bytes and array prefetch.
module spimem_rx
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              ser_clk,
  input  logic              sess_on,
  input  logic              held,
  input  logic              ser_in,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wstb_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              load_o,
  output logic              load_arr_o
);

  localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int WIRE_W     = ADDR_BYTES * BYTE_W;
  localparam int ABYTE_W    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ABYTE_W-1:0] ABYTE_LAST = ABYTE_W'(ADDR_BYTES - 1);
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [BYTE_W-2:0]  sh_q, sh_d;
  phase_e             phase_q, phase_d;
  cmd_e               cmd_q, cmd_d;
  logic [ABYTE_W-1:0] abyte_q, abyte_d;
  logic [WIRE_W-1:0]  asr_q, asr_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [ADDR_W-1:0]  rptr_q, rptr_d;
  logic [BYTE_W-1:0]  wdata_q, wdata_d;
  logic               wstb_q, wstb_d;
  logic               load_q, load_d;
  logic               larr_q, larr_d;

  logic [BYTE_W-1:0]  nb;
  logic [WIRE_W-1:0]  full_addr;
  logic               byte_end;
  logic               rd_c;
  logic [ADDR_W-1:0]  fetch_addr;

  always_comb begin
    nb         = {sh_q, ser_in};
    full_addr  = {asr_q[WIRE_W-2:0], ser_in};
    byte_end   = (bit_q == BIT_LAST);
    bit_d      = bit_q + 1'b1;
    sh_d       = nb[BYTE_W-2:0];
    phase_d    = phase_q;
    cmd_d      = cmd_q;
    abyte_d    = abyte_q;
    asr_d      = asr_q;
    addr_d     = addr_q;
    rptr_d     = rptr_q;
    wdata_d    = wdata_q;
    wstb_d     = 1'b0;
    load_d     = 1'b0;
    larr_d     = larr_q;
    rd_c       = 1'b0;
    fetch_addr = rptr_q + 1'b1;

    unique case (phase_q)
      PH_OPC: begin
        if (byte_end) begin
          cmd_d = op_decode(nb);
          case (cmd_d)
            CMD_ARR_RD, CMD_ARR_WR: phase_d = PH_ADDR;
            CMD_STAT_RD: begin
              phase_d = PH_STAT;
              load_d  = 1'b1;
              larr_d  = 1'b0;
            end
            CMD_STAT_WR: phase_d = PH_DIN;
            default:     phase_d = PH_SKIP;
          endcase
        end
      end
      PH_ADDR: begin
        asr_d = full_addr;
        if (byte_end) begin
          if (abyte_q == ABYTE_LAST) begin
            addr_d = full_addr[ADDR_W-1:0];
            if (cmd_q == CMD_ARR_RD) begin
              phase_d    = PH_ARD;
              rptr_d     = full_addr[ADDR_W-1:0];
              rd_c       = 1'b1;
              fetch_addr = full_addr[ADDR_W-1:0];
              load_d     = 1'b1;
              larr_d     = 1'b1;
            end else begin
              phase_d = PH_DIN;
            end
          end else begin
            abyte_d = abyte_q + 1'b1;
          end
        end
      end
      PH_ARD: begin
        if (byte_end) begin
          rd_c   = 1'b1;
          rptr_d = rptr_q + 1'b1;
          load_d = 1'b1;
          larr_d = 1'b1;
        end
      end
      PH_STAT: begin
        if (byte_end) begin
          load_d = 1'b1;
          larr_d = 1'b0;
        end
      end
      PH_DIN: begin
        if (byte_end) begin
          wdata_d = nb;
          wstb_d  = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge ser_clk or negedge sess_on) begin
    if (!sess_on) begin
      bit_q   <= '0;
      sh_q    <= '0;
      phase_q <= PH_OPC;
      cmd_q   <= CMD_NONE;
      abyte_q <= '0;
      asr_q   <= '0;
      addr_q  <= '0;
      rptr_q  <= '0;
      wdata_q <= '0;
      wstb_q  <= 1'b0;
      load_q  <= 1'b0;
      larr_q  <= 1'b0;
    end else if (!held) begin
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      abyte_q <= abyte_d;
      asr_q   <= asr_d;
      addr_q  <= addr_d;
      rptr_q  <= rptr_d;
      wdata_q <= wdata_d;
      wstb_q  <= wstb_d;
      load_q  <= load_d;
      larr_q  <= larr_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign wstb_o     = wstb_q;
  assign mem_rd_o   = rd_c & ~held;
  assign mem_addr_o = fetch_addr;
  assign load_o     = load_q;
  assign load_arr_o = larr_q;

endmodule

// File: rtl/spimem_tx.sv
// Falling-edge half: loads a byte at each boundary and shifts it out MSB first.
module spimem_tx
  import spimem_pkg::*;
(
  input  logic              ser_clk,
  input  logic              sess_on,
  input  logic              held,
  input  logic              load,
  input  logic              load_arr,
  input  logic [BYTE_W-1:0] arr_byte,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic              ser_out,
  output logic              ser_oe
);

  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (load) begin
      sr_d  = load_arr ? arr_byte : stat_byte;
      act_d = 1'b1;
    end else begin
      sr_d = {sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(negedge ser_clk or negedge sess_on) begin
    if (!sess_on) begin
      sr_q  <= '0;
      act_q <= 1'b0;
    end else if (!held) begin
      sr_q  <= sr_d;
      act_q <= act_d;
    end
  end

  assign ser_out = sr_q[BYTE_W-1];
  assign ser_oe  = act_q & ~held & sess_on;

endmodule

// File: rtl/spimem_front.sv
module spimem_front
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_in,
  input  logic              pause_n,
  input  logic [BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wstb_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o
);

  logic sess_on;
  logic held;
  logic load;
  logic load_arr;
  cmd_e cmd;

  spimem_sess u_sess (
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .ser_clk   (ser_clk),
    .pause_n   (pause_n),
    .sess_on_o (sess_on),
    .held_o    (held)
  );

  spimem_rx #(.ADDR_W(ADDR_W)) u_rx (
    .ser_clk    (ser_clk),
    .sess_on    (sess_on),
    .held       (held),
    .ser_in     (ser_in),
    .cmd_o      (cmd),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .wstb_o     (wstb_o),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .load_o     (load),
    .load_arr_o (load_arr)
  );

  spimem_tx u_tx (
    .ser_clk   (ser_clk),
    .sess_on   (sess_on),
    .held      (held),
    .load      (load),
    .load_arr  (load_arr),
    .arr_byte  (mem_rdata_i),
    .stat_byte (stat_i),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
  );

  assign cmd_o = cmd;

endmodule

// File: rtl/spimem_front_chk.sv
module spimem_front_chk
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              ser_clk,
  input logic              sel_n,
  input logic              sess_on,
  input logic              held,
  input logic              so_oe,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              wstb,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);

  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge ser_clk or negedge sess_on) begin
    if (!sess_on) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (mem_rd) begin
      seen_q <= 1'b1;
      last_q <= mem_addr;
    end
  end

  // R8: no drive while deselected
  always_comb begin
    if (sel_n === 1'b1) begin
      p_desel_quiet_r8: assert (so_oe === 1'b0);
    end
  end

  p_stb_pulse_r6: assert property (@(posedge ser_clk) disable iff (!sess_on)
    (wstb && !held) |=> !wstb);

  p_stb_cmd_r6: assert property (@(posedge ser_clk) disable iff (!sess_on)
    wstb |-> (cmd == CMD_STAT_WR || cmd == CMD_ARR_WR));

  p_held_freeze_r7: assert property (@(posedge ser_clk) disable iff (!sess_on)
    held |=> ($stable(cmd) && $stable(addr) && $stable(wstb)));

  p_fetch_cmd_r11: assert property (@(posedge ser_clk) disable iff (!sess_on)
    mem_rd |-> (cmd == CMD_ARR_RD));

  p_fetch_seq_r4: assert property (@(posedge ser_clk) disable iff (!sess_on)
    (mem_rd && seen_q) |-> (mem_addr == ADDR_W'(last_q + 1'b1)));

  p_drive_cmd_r5: assert property (@(posedge ser_clk) disable iff (!sess_on)
    so_oe |-> (cmd == CMD_STAT_RD || cmd == CMD_ARR_RD));

endmodule

bind spimem_front spimem_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .ser_clk  (ser_clk),
  .sel_n    (sel_n),
  .sess_on  (sess_on),
  .held     (held),
  .so_oe    (ser_oe),
  .cmd      (cmd_o),
  .addr     (addr_o),
  .wstb     (wstb_o),
  .mem_rd   (mem_rd_o),
  .mem_addr (mem_addr_o)
);

// File: tb/tb_spimem_front.sv
`timescale 1ns/1ps
module tb_spimem_front;

  logic        clk;
  logic        rst_n;
  logic        sel_n;
  logic        ser_clk;
  logic        ser_in;
  logic        pause_n;
  logic [7:0]  stat;
  logic [7:0]  mem_rdata;
  logic        ser_out;
  logic        ser_oe;
  logic [2:0]  cmd;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        wstb;
  logic        mem_rd;
  logic [12:0] mem_addr;

  int total = 0;
  int bad = 0;
  int nfetch = 0;
  int nstb = 0;
  logic idle_hi = 1'b0;
  logic ended = 1'b0;

  spimem_front dut (
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .ser_clk     (ser_clk),
    .ser_in      (ser_in),
    .pause_n     (pause_n),
    .stat_i      (stat),
    .mem_rdata_i (mem_rdata),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .cmd_o       (cmd),
    .addr_o      (addr),
    .wdata_o     (wdata),
    .wstb_o      (wstb),
    .mem_rd_o    (mem_rd),
    .mem_addr_o  (mem_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // Behavioural array: synchronous read on the rising serial clock.
  initial mem_rdata = 8'h00;
  always @(posedge ser_clk) begin
    if (mem_rd === 1'b1) begin
      mem_rdata <= pat(mem_addr);
      nfetch++;
    end
  end

  always @(negedge ser_clk) begin
    if (wstb === 1'b1) nstb++;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic o, output logic oe);
    ser_clk = 1'b0;
    ser_in  = b;
    tick();
    o  = ser_out;
    oe = ser_oe;
    ser_clk = 1'b1;
    tick();
  endtask

  task automatic byte_x(input logic [7:0] v, output logic [7:0] r,
                        output logic drv_all, output logic drv_any);
    logic o, oe;
    r = '0;
    drv_all = 1'b1;
    drv_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(v[i], o, oe);
      r = {r[6:0], o};
      drv_all = drv_all & oe;
      drv_any = drv_any | oe;
    end
  endtask

  task automatic open_sel();
    ser_clk = idle_hi;
    tick();
    sel_n = 1'b0;
    tick();
  endtask

  task automatic close_sel();
    if (!idle_hi) ser_clk = 1'b0;
    tick();
    sel_n = 1'b1;
    tick();
    tick();
  endtask

  task automatic t_reset_state();
    chk("R8", "oe in reset", int'(ser_oe), 0);
    chk("R8", "cmd in reset", int'(cmd), 0);
    chk("R8", "strobe in reset", int'(wstb), 0);
  endtask

  task automatic t_powerup_r9();
    logic [7:0] r;
    logic da, dy;
    rst_n = 1'b1;
    tick();
    stat = 8'h5A;
    byte_x(8'h05, r, da, dy);
    chk("R9", "cmd before first deselect", int'(cmd), 0);
    byte_x(8'h00, r, da, dy);
    chk("R9", "drive before first deselect", int'(dy), 0);
    close_sel();
  endtask

  task automatic t_opcodes_r1();
    logic [7:0] ops [6] = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02};
    int codes [6] = '{1, 2, 3, 4, 5, 6};
    logic [7:0] r;
    logic da, dy;
    for (int k = 0; k < 6; k++) begin
      open_sel();
      byte_x(ops[k], r, da, dy);
      chk("R1", "decoded code", int'(cmd), codes[k]);
      close_sel();
      chk("R8", "cmd cleared by deselect", int'(cmd), 0);
    end
  endtask

  task automatic t_status_r5();
    logic [7:0] r;
    logic da, dy;
    stat = 8'hA5;
    open_sel();
    byte_x(8'h05, r, da, dy);
    byte_x(8'h00, r, da, dy);
    chk("R5", "status byte", int'(r), 8'hA5);
    chk("R5", "status driven", int'(da), 1);
    stat = 8'h3C;
    byte_x(8'h00, r, da, dy);
    chk("R5", "status recaptured", int'(r), 8'h3C);
    close_sel();
    chk("R8", "oe after status", int'(ser_oe), 0);
  endtask

  task automatic t_read(input string rq, input logic [15:0] a, input int n);
    logic [7:0] r;
    logic da, dy;
    logic [12:0] exp_a;
    int f0;
    f0 = nfetch;
    open_sel();
    byte_x(8'h03, r, da, dy);
    byte_x(a[15:8], r, da, dy);
    byte_x(a[7:0], r, da, dy);
    chk("R3", "captured address", int'(addr), int'(a[12:0]));
    exp_a = a[12:0];
    for (int i = 0; i < n; i++) begin
      byte_x(8'hFF, r, da, dy);
      chk(rq, "read byte", int'(r), int'(pat(exp_a)));
      chk(rq, "read driven", int'(da), 1);
      exp_a = exp_a + 13'd1;
    end
    close_sel();
    chk("R11", "fetch count", nfetch - f0, n + 1);
    chk("R8", "oe after read", int'(ser_oe), 0);
  endtask

  task automatic t_write_r6();
    logic [7:0] r;
    logic da, dy;
    int s0;
    s0 = nstb;
    open_sel();
    byte_x(8'h02, r, da, dy);
    byte_x(8'hEA, r, da, dy);
    byte_x(8'hBC, r, da, dy);
    chk("R3", "write address", int'(addr), 13'h0ABC);
    chk("R6", "no strobe before data", int'(wstb), 0);
    byte_x(8'h5A, r, da, dy);
    chk("R6", "strobe after byte 1", int'(wstb), 1);
    chk("R6", "data byte 1", int'(wdata), 8'h5A);
    byte_x(8'hC3, r, da, dy);
    chk("R6", "data byte 2", int'(wdata), 8'hC3);
    close_sel();
    chk("R6", "strobe count", nstb - s0, 2);
    s0 = nstb;
    open_sel();
    byte_x(8'h01, r, da, dy);
    byte_x(8'h8C, r, da, dy);
    chk("R6", "status write strobe", int'(wstb), 1);
    chk("R6", "status write data", int'(wdata), 8'h8C);
    close_sel();
    chk("R6", "status write strobe count", nstb - s0, 1);
  endtask

  task automatic t_unknown_r2();
    logic [7:0] r;
    logic da, dy, any;
    int f0, s0;
    f0 = nfetch;
    s0 = nstb;
    any = 1'b0;
    open_sel();
    byte_x(8'hA7, r, da, dy);
    any = any | dy;
    byte_x(8'h03, r, da, dy);
    any = any | dy;
    byte_x(8'h00, r, da, dy);
    any = any | dy;
    byte_x(8'h00, r, da, dy);
    any = any | dy;
    byte_x(8'h00, r, da, dy);
    any = any | dy;
    chk("R2", "cmd after unknown opcode", int'(cmd), 0);
    chk("R2", "drive after unknown opcode", int'(any), 0);
    close_sel();
    chk("R2", "fetches after unknown opcode", nfetch - f0, 0);
    chk("R2", "strobes after unknown opcode", nstb - s0, 0);
  endtask

  task automatic t_partial_r8();
    logic o, oe;
    logic [7:0] r;
    logic da, dy;
    open_sel();
    bit_x(1'b1, o, oe);
    bit_x(1'b0, o, oe);
    bit_x(1'b1, o, oe);
    bit_x(1'b0, o, oe);
    close_sel();
    chk("R8", "cmd after cut command", int'(cmd), 0);
    stat = 8'h96;
    open_sel();
    byte_x(8'h05, r, da, dy);
    chk("R8", "fresh opcode after cut", int'(cmd), 3);
    byte_x(8'h00, r, da, dy);
    chk("R8", "status after cut", int'(r), 8'h96);
    close_sel();
  endtask

  task automatic t_pause_r7();
    logic [7:0] r;
    logic o, oe, da, dy;
    int f0;
    f0 = nfetch;
    open_sel();
    byte_x(8'h03, r, da, dy);
    byte_x(8'h03, r, da, dy);
    byte_x(8'h45, r, da, dy);
    r = '0;
    for (int i = 0; i < 3; i++) begin
      bit_x(1'b0, o, oe);
      r = {r[6:0], o};
    end
    ser_clk = 1'b0;
    tick();
    pause_n = 1'b0;
    tick();
    chk("R7", "oe while paused", int'(ser_oe), 0);
    for (int i = 0; i < 4; i++) begin
      ser_in = ~ser_in;
      ser_clk = 1'b1;
      tick();
      ser_clk = 1'b0;
      tick();
    end
    chk("R7", "oe after paused clocks", int'(ser_oe), 0);
    chk("R7", "cmd kept while paused", int'(cmd), 5);
    chk("R7", "address kept while paused", int'(addr), 13'h0345);
    pause_n = 1'b1;
    tick();
    for (int i = 0; i < 5; i++) begin
      bit_x(1'b0, o, oe);
      r = {r[6:0], o};
    end
    chk("R7", "byte across pause", int'(r), int'(pat(13'h0345)));
    byte_x(8'h00, r, da, dy);
    chk("R7", "byte after pause", int'(r), int'(pat(13'h0346)));
    close_sel();
    chk("R7", "fetches with pause", nfetch - f0, 3);
  endtask

  task automatic t_idle_high_r10();
    logic [7:0] r;
    logic da, dy;
    idle_hi = 1'b1;
    stat = 8'h71;
    open_sel();
    byte_x(8'h05, r, da, dy);
    byte_x(8'h00, r, da, dy);
    chk("R10", "status with clock idling high", int'(r), 8'h71);
    close_sel();
    t_read("R10", 16'h0100, 2);
    idle_hi = 1'b0;
    ser_clk = 1'b0;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    sel_n   = 1'b0;
    ser_clk = 1'b0;
    ser_in  = 1'b0;
    pause_n = 1'b1;
    stat    = 8'h00;
    tick();
    tick();
    t_reset_state();
    t_powerup_r9();
    t_reset_state();
    t_opcodes_r1();
    t_status_r5();
    t_read("R4", 16'hF234, 2);
    t_read("R4", 16'h1FFE, 3);
    t_write_r6();
    t_unknown_r2();
    t_partial_r8();
    t_pause_r7();
    t_idle_high_r10();
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule